// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block stores eight 16-bit registers for a processor datapath. The first four are general registers that can be used as full words or as two independent 8-bit halves. Each half shares storage with the word view. The remaining four registers hold the stack pointer, the base pointer, the source index and the destination index, and they are reachable only as whole words.

The file has one write port and two read ports. Every port carries a register index and a byte/word select. Reads are combinational from the stored state. A write lands at the rising clock edge, so a read that targets the register being written in the same cycle still returns the old contents. A synchronous reset clears the whole file to zero.

Top module: `gp_regfile`

## Requirements
- R1: In word mode (select bit = 0) the 3-bit index picks the register in the order 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI, and a word read returns the full 16-bit contents.
- R2: In byte mode (select bit = 1) indices 0..3 pick the low halves AL, CL, DL, BL (bits 7:0 of word registers 0..3). Indices 4..7 pick the high halves AH, CH, DH, BH (bits 15:8 of word registers 0..3). No byte index ever reaches SP, BP, SI or DI.
- R3: A byte write stores write-data bits 7:0 into the selected half only. The other half of the same register keeps its value, and a later word read shows the combined result.
- R4: A byte read returns the selected half in bits 7:0 of the read data, with bits 15:8 driven to zero.
- R5: A word write replaces all 16 bits of the selected register, including the four word-only registers.
- R6: While reset is high at a rising clock edge, every register becomes zero at that edge.
- R7: When the write enable is low, no register changes at the clock edge, whatever the other write inputs carry.
- R8: A read of a register that is written in the same cycle returns the contents from before the write. The new value is visible from the following cycle on.
- R9: The two read ports select and return data independently of each other and of the write port.
- R10: A write changes only its target register. The other seven registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write access size: 0 = word, 1 = byte |
| wr_idx | input | 3 | Write register index, decoded per the access size |
| wr_data | input | 16 | Write data; bits 7:0 are used for byte writes |
| rd_byte | input | 2 | Per read port access size: 0 = word, 1 = byte |
| rd_idx | input | 6 | Per read port register index, 3 bits per port, port 0 in bits 2:0 |
| rd_data | output | 32 | Per read port data, 16 bits per port, port 0 in bits 15:0 |

## Verification
The assertions take for granted that reset is held high for at least one clock edge before normal use. They also assume every input is at a known 0/1 level at each rising edge; nothing else about the input sequence is constrained. The stimulus sets every port at the falling edge and holds it through the next rising edge. Its random phase draws every index, access size and data value from the full legal ranges. It mixes in sparse reset pulses and idle cycles with garbage on the write inputs, so every check runs on defined inputs.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;

   // access size carried by each port of the file
   typedef enum logic {
      ACC_WORD = 1'b0,
      ACC_BYTE = 1'b1
   } acc_mode_e;

endpackage : gpr_pkg

// File: rtl/gpr_index_decode.sv
`timescale 1ns/1ps
// Maps a port index plus access size onto a word register number and a
// half select. Byte indices fold onto the splittable registers only.
module gpr_index_decode
   import gpr_pkg::*;
#(
   parameter int NUM_REGS  = 8,
   parameter int NUM_SPLIT = 4,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0] idx,
   input  acc_mode_e        mode,
   output logic [IDX_W-1:0] reg_num,
   output logic             hi_half
);

   always_comb begin
      if (mode == ACC_BYTE) begin
         // upper index bit picks the half, the rest picks the register
         reg_num = {1'b0, idx[IDX_W-2:0]};
         hi_half = idx[IDX_W-1];
      end else begin
         reg_num = idx;
         hi_half = 1'b0;
      end
   end

endmodule : gpr_index_decode

// File: rtl/gpr_write_lane.sv
`timescale 1ns/1ps
// Storage for one register. A splittable register keeps two half-width
// flop groups with their own enables; a word-only register keeps one.
module gpr_write_lane #(
   parameter int DATA_W = 16,
   parameter bit SPLIT  = 1'b1,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   generate
      if (SPLIT) begin : g_split
         logic [HALF_W-1:0] lo_q;
         logic [HALF_W-1:0] hi_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               lo_q <= '0;
            end else if (we_lo) begin
               lo_q <= d[HALF_W-1:0];
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               hi_q <= '0;
            end else if (we_hi) begin
               hi_q <= d[DATA_W-1:HALF_W];
            end
         end

         assign q = {hi_q, lo_q};
      end else begin : g_word
         logic [DATA_W-1:0] w_q;
         logic              we;

         assign we = we_lo | we_hi;

         always_ff @(posedge clk) begin
            if (rst) begin
               w_q <= '0;
            end else if (we) begin
               w_q <= d;
            end
         end

         assign q = w_q;
      end
   endgenerate

endmodule : gpr_write_lane

// File: rtl/gpr_read_port.sv
`timescale 1ns/1ps
// One combinational read port: register select, then half extract with
// zero extension for byte accesses.
module gpr_read_port
   import gpr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NUM_REGS  = 8,
   parameter int NUM_SPLIT = 4,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int HALF_W   = DATA_W / 2
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [IDX_W-1:0]                idx,
   input  acc_mode_e                       mode,
   output logic [DATA_W-1:0]               data
);

   logic [IDX_W-1:0]  reg_num;
   logic              hi_half;
   logic [DATA_W-1:0] word;
   logic [HALF_W-1:0] half;

   gpr_index_decode #(
      .NUM_REGS  (NUM_REGS),
      .NUM_SPLIT (NUM_SPLIT)
   ) u_dec (
      .idx     (idx),
      .mode    (mode),
      .reg_num (reg_num),
      .hi_half (hi_half)
   );

   assign word = regs[reg_num];
   assign half = hi_half ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];

   always_comb begin
      if (mode == ACC_BYTE) begin
         data = {{HALF_W{1'b0}}, half};
      end else begin
         data = word;
      end
   end

endmodule : gpr_read_port

// File: rtl/gp_regfile.sv
`timescale 1ns/1ps
// Byte-splittable general register file: one write port, NUM_RD read ports.
module gp_regfile
   import gpr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NUM_REGS  = 8,
   parameter int NUM_SPLIT = 4,
   parameter int NUM_RD    = 2,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int HALF_W   = DATA_W / 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic                           wr_byte,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [NUM_RD-1:0]              rd_byte,
   input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

   // elaboration-time parameter checks
   initial begin
      assert (DATA_W >= 2 && DATA_W % 2 == 0)
         else $error("gp_regfile: DATA_W must be even");
      assert (NUM_REGS == (1 << IDX_W))
         else $error("gp_regfile: NUM_REGS must be a power of two");
      assert (2 * NUM_SPLIT == NUM_REGS)
         else $error("gp_regfile: byte index space must equal NUM_REGS");
      assert (NUM_RD >= 1)
         else $error("gp_regfile: need at least one read port");
   end

   acc_mode_e                       wr_mode;
   logic [IDX_W-1:0]                wr_reg;
   logic                            wr_hi;
   logic [DATA_W-1:0]               lane_d;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

   assign wr_mode = acc_mode_e'(wr_byte);

   gpr_index_decode #(
      .NUM_REGS  (NUM_REGS),
      .NUM_SPLIT (NUM_SPLIT)
   ) u_wdec (
      .idx     (wr_idx),
      .mode    (wr_mode),
      .reg_num (wr_reg),
      .hi_half (wr_hi)
   );

   // byte writes replicate the low byte so either half can take it
   assign lane_d = (wr_mode == ACC_BYTE) ?
                   {wr_data[HALF_W-1:0], wr_data[HALF_W-1:0]} : wr_data;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic hit;
         logic we_lo;
         logic we_hi;

         assign hit   = wr_en && (wr_reg == IDX_W'(r));
         assign we_lo = hit && ((wr_mode == ACC_WORD) || !wr_hi);
         assign we_hi = hit && ((wr_mode == ACC_WORD) ||  wr_hi);

         gpr_write_lane #(
            .DATA_W (DATA_W),
            .SPLIT  (r < NUM_SPLIT)
         ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .we_lo (we_lo),
            .we_hi (we_hi),
            .d     (lane_d),
            .q     (regs_q[r])
         );
      end

      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         gpr_read_port #(
            .DATA_W    (DATA_W),
            .NUM_REGS  (NUM_REGS),
            .NUM_SPLIT (NUM_SPLIT)
         ) u_rd (
            .regs (regs_q),
            .idx  (rd_idx[p]),
            .mode (acc_mode_e'(rd_byte[p])),
            .data (rd_data[p])
         );
      end
   endgenerate

endmodule : gp_regfile

// File: rtl/gpr_checker.sv
`timescale 1ns/1ps
module gpr_checker #(
   parameter int DATA_W    = 16,
   parameter int NUM_REGS  = 8,
   parameter int NUM_RD    = 2,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int HALF_W   = DATA_W / 2
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           wr_en,
   input logic                           wr_byte,
   input logic [IDX_W-1:0]               wr_idx,
   input logic [DATA_W-1:0]              wr_data,
   input logic [NUM_RD-1:0]              rd_byte,
   input logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
   input logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
   input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);

   // snapshot of the previous cycle's write request and state
   logic                            p_valid;
   logic                            p_en;
   logic                            p_byte;
   logic [IDX_W-1:0]                p_idx;
   logic [DATA_W-1:0]               p_data;
   logic [NUM_REGS-1:0][DATA_W-1:0] p_regs;
   logic [IDX_W-1:0]                p_tgt;
   logic                            p_hi;

   always_ff @(posedge clk) begin
      p_valid <= !rst;
      p_en    <= wr_en;
      p_byte  <= wr_byte;
      p_idx   <= wr_idx;
      p_data  <= wr_data;
      p_regs  <= regs;
   end

   assign p_tgt = p_byte ? {1'b0, p_idx[IDX_W-2:0]} : p_idx;
   assign p_hi  = p_byte && p_idx[IDX_W-1];

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (regs == '0)); // R6

   AST_WORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (p_valid && p_en && !p_byte) |-> (regs[p_idx] == p_data)); // R5

   AST_BYTE_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
      (p_valid && p_en && p_byte) |->
         (p_hi ? (regs[p_tgt] == {p_data[HALF_W-1:0], p_regs[p_tgt][HALF_W-1:0]})
               : (regs[p_tgt] == {p_regs[p_tgt][DATA_W-1:HALF_W], p_data[HALF_W-1:0]}))); // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (p_valid && !p_en) |-> (regs == p_regs)); // R7

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_keep
         AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (rst)
            (p_valid && !(p_en && (p_tgt == IDX_W'(r)))) |-> (regs[r] == p_regs[r])); // R10
      end

      for (genvar p = 0; p < NUM_RD; p++) begin : g_port
         AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (rst)
            rd_byte[p] |-> (rd_data[p][DATA_W-1:HALF_W] == '0)); // R4

         AST_BYTE_READ_HALF: assert property (@(posedge clk) disable iff (rst)
            rd_byte[p] |-> (rd_data[p][HALF_W-1:0] == (rd_idx[p][IDX_W-1] ?
               regs[{1'b0, rd_idx[p][IDX_W-2:0]}][DATA_W-1:HALF_W] :
               regs[{1'b0, rd_idx[p][IDX_W-2:0]}][HALF_W-1:0]))); // R2

         AST_WORD_READ_MATCH: assert property (@(posedge clk) disable iff (rst)
            !rd_byte[p] |-> (rd_data[p] == regs[rd_idx[p]])); // R1
      end
   endgenerate

endmodule : gpr_checker

bind gp_regfile gpr_checker #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .NUM_RD   (NUM_RD)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .wr_byte (wr_byte),
   .wr_idx  (wr_idx),
   .wr_data (wr_data),
   .rd_byte (rd_byte),
   .rd_idx  (rd_idx),
   .rd_data (rd_data),
   .regs    (regs_q)
);

// File: tb/sim_gp_regfile.sv
`timescale 1ns/1ps
module sim_gp_regfile;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            wr_en = 1'b0;
   logic            wr_byte = 1'b0;
   logic [2:0]      wr_idx = '0;
   logic [15:0]     wr_data = '0;
   logic [1:0]      rd_byte = '0;
   logic [1:0][2:0] rd_idx = '0;
   logic [1:0][15:0] rd_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [15:0] model [8];

   always #10 clk = ~clk; // 50 MHz

   gp_regfile u0 (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_byte (wr_byte),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_byte (rd_byte),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   function automatic logic [15:0] exp_read(input logic b, input logic [2:0] i);
      if (b) begin
         if (i[2]) return {8'h00, model[{1'b0, i[1:0]}][15:8]};
         else      return {8'h00, model[{1'b0, i[1:0]}][7:0]};
      end
      return model[i];
   endfunction

   function automatic void model_write(input logic b, input logic [2:0] i,
                                       input logic [15:0] d);
      if (b) begin
         if (i[2]) model[{1'b0, i[1:0]}][15:8] = d[7:0];
         else      model[{1'b0, i[1:0]}][7:0]  = d[7:0];
      end else begin
         model[i] = d;
      end
   endfunction

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, compare reads before the rising edge,
   // then advance the model past the edge
   task automatic step(input logic r, input logic we, input logic wb,
                       input logic [2:0] wi, input logic [15:0] wd,
                       input logic b0, input logic [2:0] i0,
                       input logic b1, input logic [2:0] i1,
                       input bit do_chk, input string req);
      @(negedge clk);
      rst = r; wr_en = we; wr_byte = wb; wr_idx = wi; wr_data = wd;
      rd_byte = {b1, b0}; rd_idx[0] = i0; rd_idx[1] = i1;
      #1;
      if (do_chk) begin
         check(req, rd_data[0], exp_read(b0, i0));
         check(req, rd_data[1], exp_read(b1, i1));
      end
      @(posedge clk);
      if (r) begin
         for (int k = 0; k < 8; k++) model[k] = '0;
      end else if (we) begin
         model_write(wb, wi, wd);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
   endtask

   initial begin
      for (int k = 0; k < 8; k++) model[k] = '0;
      void'($urandom(32'd4711));

      repeat (3) step(1, 0, 0, 0, 16'h0, 0, 0, 0, 0, 0, "R6");
      // R6: reset state, every word reads zero
      for (int k = 0; k < 8; k += 2)
         step(0, 0, 0, 0, 16'h0, 0, 3'(k), 0, 3'(k + 1), 1, "R6 reset zero");

      // R5 word write into AX, then R2/R4 byte views of it
      step(0, 1, 0, 3'd0, 16'h1234, 0, 0, 0, 1, 1, "R5");
      step(0, 0, 0, 0, 16'h0, 1, 3'd0, 1, 3'd4, 1, "R2 R4 AL/AH of AX");
      // R3: high byte write keeps low byte
      step(0, 1, 1, 3'd4, 16'hFFAB, 0, 0, 0, 0, 1, "R3");
      step(0, 0, 0, 0, 16'h0, 0, 3'd0, 1, 3'd4, 1, "R3 AX after AH write");
      // R3: BL write (byte index 3) keeps BH
      step(0, 1, 0, 3'd3, 16'hC0DE, 0, 3, 0, 3, 1, "R5 BX");
      step(0, 1, 1, 3'd3, 16'h0077, 0, 3, 1, 3'd7, 1, "R3");
      step(0, 0, 0, 0, 16'h0, 0, 3'd3, 1, 3'd7, 1, "R3 BX after BL write");
      // R1/R2: word-only SP vs byte index 4 (AH)
      step(0, 1, 0, 3'd4, 16'hBEEF, 0, 4, 0, 0, 1, "R1 SP write");
      step(0, 1, 1, 3'd4, 16'h0055, 0, 4, 0, 0, 1, "R2");
      step(0, 0, 0, 0, 16'h0, 0, 3'd4, 0, 3'd0, 1, "R2 SP untouched by byte idx 4");
      // R1: DI at the top index
      step(0, 1, 0, 3'd7, 16'hA5A5, 0, 7, 0, 6, 1, "R1");
      step(0, 0, 0, 0, 16'h0, 0, 3'd7, 0, 3'd6, 1, "R1 DI/SI");
      // R8: same-cycle write and read of CX returns old value, new next cycle
      step(0, 1, 0, 3'd1, 16'h9876, 0, 3'd1, 1, 3'd5, 1, "R8 old value");
      step(0, 0, 0, 0, 16'h0, 0, 3'd1, 1, 3'd5, 1, "R8 new value");
      // R7: write enable low ignores garbage on write inputs
      step(0, 0, 0, 3'd2, 16'hDEAD, 0, 2, 0, 2, 1, "R7");
      step(0, 0, 1, 3'd6, 16'hBEEF, 0, 3'd2, 0, 3'd6, 1, "R7 no change");

      // R9 R10: random mix, both read ports independent
      for (int n = 0; n < 1500; n++) begin
         logic r;
         r = ($urandom % 97) == 0;
         step(r, ($urandom % 4) != 0, 1'($urandom), 3'($urandom),
              16'($urandom), 1'($urandom), 3'($urandom),
              1'($urandom), 3'($urandom), 1,
              r ? "R6 random reset" : "R9 R10 random");
      end

      // R6: reset after activity clears everything
      step(1, 1, 0, 3'd0, 16'hFFFF, 0, 0, 0, 0, 0, "R6");
      for (int k = 0; k < 8; k += 2)
         step(0, 0, 0, 0, 16'h0, 0, 3'(k), 0, 3'(k + 1), 1, "R6 cleared");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

endmodule : sim_gp_regfile